// File: doc/BRIEF.md
# Tree-Based Multi-Branch Outcome Predictor

The block predicts the taken or not-taken outcomes of several consecutive conditional branches in a single lookup. Each row of its table holds a whole binary tree of 2-bit saturating counters, with one counter per branch position that can be reached. The row also holds a tag and a cached copy of the path that the tree currently favours. A lookup is keyed by the global branch history. It selects a row by the low history bits and checks the higher bits against the stored tag. On a match it returns the cached path.

Training is deferred until the real path of branches has completed. The completed path walks the tree from the root, and each counter it passes is stepped toward the direction actually taken. The block then walks the updated tree again, following the most significant bit of each counter, and stores the result as the new cached path. A completed path whose row holds another tag, or a row never written, replaces that row. The new row's tree starts from weakly not-taken counters and is then trained once.

Top module: `tmbp_top`

## Requirements
- R1: A counter value of 2 or 3 means taken and a value of 0 or 1 means not taken. Path bit 0 is the first branch, and a bit value of 1 means taken. Every counter stays within 0..3.
- R2: The row index is hist[IDX_W-1:0] and the tag is hist[IDX_W+TAG_W-1:IDX_W]. The same index with a different tag is a miss.
- R3: The cycle after a clock edge with lk_valid high shows pr_valid high and that lookup's result. The cycle after an edge with lk_valid low shows pr_valid, pr_hit and pr_path all zero.
- R4: A lookup that misses returns pr_hit low and pr_path all zero.
- R5: After reset every row is invalid, so every lookup misses.
- R6: An update that misses writes the tag and marks the row valid. It sets every counter to 1 and then trains them along the completed path, so that the cached path equals the completed path.
- R7: An update that hits steps each counter on the completed path by one toward its branch's outcome, saturating at 0 and 3. Counters off the path are left unchanged.
- R8: After every update the cached path is rebuilt by walking the updated tree from the root. Each step follows the taken child when the current counter's MSB is 1, and the not-taken child otherwise.
- R9: When a lookup and an update address the same row in the same cycle, the lookup returns the state as it is after the update.
- R10: A lookup has no effect on the table, so repeated lookups of a row return the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_hist | input | IDX_W+TAG_W | Global history keying the lookup |
| up_valid | input | 1 | Completed-path update request |
| up_hist | input | IDX_W+TAG_W | Global history that the completed path was predicted under |
| up_path | input | DEPTH | Real outcomes, bit 0 first, 1 = taken |
| pr_valid | output | 1 | A lookup result is present |
| pr_hit | output | 1 | Row valid and tag matched |
| pr_path | output | DEPTH | Predicted outcomes, bit 0 first, 1 = taken |

## Verification
A wrong counter is not visible at once. It appears only when a later walk passes through that node, so it shows up as a cached path that differs from the model. That difference can appear several updates after the bad step, for example when a counter wraps instead of saturating. A corrupted tag or valid bit appears on the next lookup of that row as a wrong pr_hit. The bench compares every output against a behavioural model on every cycle, and directed sequences drive counters across their thresholds and their saturation points so that these faults surface within a few cycles.

// File: rtl/tmbp_pkg.sv
package tmbp_pkg;
  localparam logic [1:0] CTR_WEAK_NT = 2'b01;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] r;
    r = c;
    if (taken && c != 2'b11) r = c + 2'b01;
    else if (!taken && c != 2'b00) r = c - 2'b01;
    return r;
  endfunction
endpackage

// File: rtl/tmbp_path_train.sv
module tmbp_path_train #(
  parameter int DEPTH = 4,
  localparam int NODES = (1 << DEPTH) - 1
) (
  input  logic [NODES-1:0][1:0] tree_i,
  input  logic [DEPTH-1:0]      path_i,
  output logic [NODES-1:0][1:0] tree_o
);
  import tmbp_pkg::*;

  logic [DEPTH-1:0] node;

  always_comb begin
    tree_o = tree_i;
    node   = '0;
    for (int l = 0; l < DEPTH; l++) begin
      tree_o[node] = ctr_step(tree_i[node], path_i[l]);
      node = (node << 1) + DEPTH'(1) + DEPTH'(path_i[l]);
    end
  end
endmodule

// File: rtl/tmbp_path_walk.sv
module tmbp_path_walk #(
  parameter int DEPTH = 4,
  localparam int NODES = (1 << DEPTH) - 1
) (
  input  logic [NODES-1:0][1:0] tree_i,
  output logic [DEPTH-1:0]      path_o
);
  logic [DEPTH-1:0] node_w [DEPTH];

  assign node_w[0] = '0;

  for (genvar l = 0; l < DEPTH; l++) begin : g_level
    assign path_o[l] = tree_i[node_w[l]][1];
    if (l < DEPTH - 1) begin : g_next
      assign node_w[l+1] = (node_w[l] << 1) + DEPTH'(1) + DEPTH'(path_o[l]);
    end
  end
endmodule

// File: rtl/tmbp_top.sv
module tmbp_top #(
  parameter int IDX_W = 5,
  parameter int TAG_W = 6,
  parameter int DEPTH = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   lk_valid,
  input  logic [IDX_W+TAG_W-1:0] lk_hist,
  input  logic                   up_valid,
  input  logic [IDX_W+TAG_W-1:0] up_hist,
  input  logic [DEPTH-1:0]       up_path,
  output logic                   pr_valid,
  output logic                   pr_hit,
  output logic [DEPTH-1:0]       pr_path
);
  import tmbp_pkg::*;

  localparam int ENTRIES = 1 << IDX_W;
  localparam int NODES   = (1 << DEPTH) - 1;
  localparam int HIST_W  = IDX_W + TAG_W;

  typedef logic [NODES-1:0][1:0] tree_t;

  tree_t              tree_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_q   [ENTRIES];
  logic [DEPTH-1:0]   cpath_q [ENTRIES];
  logic [ENTRIES-1:0] valid_q, valid_d;

  logic [IDX_W-1:0] up_idx, lk_idx;
  logic [TAG_W-1:0] up_tag, lk_tag;
  logic             up_hit;
  tree_t            base_tree, new_tree;
  logic [DEPTH-1:0] new_path;

  assign up_idx = up_hist[IDX_W-1:0];
  assign up_tag = up_hist[HIST_W-1:IDX_W];
  assign lk_idx = lk_hist[IDX_W-1:0];
  assign lk_tag = lk_hist[HIST_W-1:IDX_W];

  // Miss: start from a weakly not-taken tree before training
  assign up_hit    = valid_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign base_tree = up_hit ? tree_q[up_idx] : {NODES{CTR_WEAK_NT}};

  tmbp_path_train #(.DEPTH(DEPTH)) u_train (
    .tree_i (base_tree),
    .path_i (up_path),
    .tree_o (new_tree)
  );

  tmbp_path_walk #(.DEPTH(DEPTH)) u_walk (
    .tree_i (new_tree),
    .path_o (new_path)
  );

  always_comb begin
    valid_d         = valid_q;
    valid_d[up_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else if (up_valid) valid_q <= valid_d;
  end

  // Table payload carries no reset: valid_q guards every read
  always_ff @(posedge clk) begin
    if (up_valid) begin
      tree_q[up_idx]  <= new_tree;
      tag_q[up_idx]   <= up_tag;
      cpath_q[up_idx] <= new_path;
    end
  end

  // Lookup with same-cycle update forwarding
  logic             byp;
  logic             eff_valid, hit_d;
  logic [TAG_W-1:0] eff_tag;
  logic [DEPTH-1:0] eff_path, path_d;

  always_comb begin
    byp       = up_valid && (up_idx == lk_idx);
    eff_valid = byp ? 1'b1     : valid_q[lk_idx];
    eff_tag   = byp ? up_tag   : tag_q[lk_idx];
    eff_path  = byp ? new_path : cpath_q[lk_idx];
    hit_d     = lk_valid && eff_valid && (eff_tag == lk_tag);
    path_d    = hit_d ? eff_path : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_valid <= 1'b0;
      pr_hit   <= 1'b0;
      pr_path  <= '0;
    end else begin
      pr_valid <= lk_valid;
      pr_hit   <= hit_d;
      pr_path  <= path_d;
    end
  end

  assert_lookup_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> pr_valid);
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> (!pr_valid && !pr_hit && pr_path == '0));
  assert_miss_path_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pr_hit |-> pr_path == '0);
  assert_alloc_tag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> (valid_q[$past(up_idx)] && tag_q[$past(up_idx)] == $past(up_tag)));
  assert_root_path_R8: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> cpath_q[$past(up_idx)][0] == tree_q[$past(up_idx)][0][1]);
  assert_lookup_pure_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(valid_q));
endmodule

// File: tb/tmbp_top_test.sv
module tmbp_top_test;
  localparam int IDX_W = 5, TAG_W = 6, DEPTH = 4;
  localparam int HW = IDX_W + TAG_W;
  localparam int ENT = 1 << IDX_W;
  localparam int NN = (1 << DEPTH) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic lk_valid = 1'b0, up_valid = 1'b0;
  logic [HW-1:0] lk_hist = '0, up_hist = '0;
  logic [DEPTH-1:0] up_path = '0;
  logic pr_valid, pr_hit;
  logic [DEPTH-1:0] pr_path;

  int tests = 0, fails = 0;
  bit done = 0;

  int m_valid [ENT];
  int m_tag   [ENT];
  int m_ctr   [ENT][NN];
  int m_path  [ENT];

  always #4 clk = ~clk;

  tmbp_top #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_hist(lk_hist),
    .up_valid(up_valid), .up_hist(up_hist), .up_path(up_path),
    .pr_valid(pr_valid), .pr_hit(pr_hit), .pr_path(pr_path));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int walk(input int e);
    int n = 0, p = 0;
    for (int l = 0; l < DEPTH; l++) begin
      int b = (m_ctr[e][n] >= 2) ? 1 : 0;
      p = p | (b << l);
      n = 2 * n + 1 + b;
    end
    return p;
  endfunction

  task automatic model_update(input int h, input int pth);
    int e = h % ENT, t = h / ENT, n = 0;
    if (!(m_valid[e] != 0 && m_tag[e] == t)) begin
      for (int k = 0; k < NN; k++) m_ctr[e][k] = 1;
      m_tag[e] = t;
      m_valid[e] = 1;
    end
    for (int l = 0; l < DEPTH; l++) begin
      int b = (pth >> l) & 1;
      if (b == 1 && m_ctr[e][n] < 3) m_ctr[e][n]++;
      if (b == 0 && m_ctr[e][n] > 0) m_ctr[e][n]--;
      n = 2 * n + 1 + b;
    end
    m_path[e] = walk(e);
  endtask

  // One cycle: drive, predict with update applied first, sample after the edge
  task automatic step(input bit lv, input int lh, input bit uv, input int uh,
                      input int up, input string req,
                      input bit dchk = 0, input int dhit = 0, input int dpath = 0);
    int ev, eh, ep, e;
    @(negedge clk);
    lk_valid = lv; lk_hist = HW'(lh);
    up_valid = uv; up_hist = HW'(uh); up_path = DEPTH'(up);
    if (uv) model_update(uh, up);
    e  = lh % ENT;
    ev = lv ? 1 : 0;
    eh = (lv && m_valid[e] != 0 && m_tag[e] == lh / ENT) ? 1 : 0;
    ep = eh ? m_path[e] : 0;
    @(posedge clk); #2;
    chk(pr_valid == ev[0], {req, " pr_valid"}, int'(pr_valid), ev);
    chk(pr_hit == eh[0], {req, " pr_hit"}, int'(pr_hit), eh);
    chk(int'(pr_path) == ep, {req, " pr_path"}, int'(pr_path), ep);
    if (dchk) begin
      chk(int'(pr_hit) == dhit, {req, " direct hit"}, int'(pr_hit), dhit);
      chk(int'(pr_path) == dpath, {req, " direct path"}, int'(pr_path), dpath);
    end
    lk_valid = 0; up_valid = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int e = 0; e < ENT; e++) m_valid[e] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(0, 0, 0, 0, 0, "R3 idle");
    step(1, 'h0A3, 0, 0, 0, "R5 after reset", 1, 0, 0);
    step(0, 0, 1, 'h0A3, 'b1010, "R6 alloc");
    step(1, 'h0A3, 0, 0, 0, "R6 R8 alloc path", 1, 1, 'b1010);
    step(1, 'h0C3, 0, 0, 0, "R2 R4 tag mismatch", 1, 0, 0);
    step(0, 0, 1, 'h0A3, 'b1111, "R7 train");
    step(1, 'h0A3, 0, 0, 0, "R7 hysteresis", 1, 1, 'b1010);
    step(0, 0, 1, 'h0A3, 'b1111, "R7 train");
    step(1, 'h0A3, 0, 0, 0, "R1 R8 flip", 1, 1, 'b1111);
    step(1, 'h029, 1, 'h029, 'b0110, "R9 bypass", 1, 1, 'b0110);
    for (int k = 0; k < 3; k++) step(1, 'h0A3, 0, 0, 0, "R10 repeat", 1, 1, 'b1111);
    step(0, 0, 1, 'h0A3, 'b1111, "R7 sat");
    step(0, 0, 1, 'h0A3, 'b1111, "R7 sat");
    step(0, 0, 1, 'h0A3, 'b0000, "R7 sat down");
    step(1, 'h0A3, 0, 0, 0, "R7 saturated root", 1, 1, 'b1111);
    step(0, 0, 1, 'h0A3, 'b0000, "R7 down");
    step(1, 'h0A3, 0, 0, 0, "R1 R8 back to nt", 1, 1, 'b0000);
    for (int k = 0; k < 4000; k++) begin
      int lh = ($urandom_range(0, 1) << IDX_W) | $urandom_range(0, 3);
      int uh = ($urandom_range(0, 1) << IDX_W) | $urandom_range(0, 3);
      step($urandom_range(0, 1), lh, $urandom_range(0, 2) == 0, uh,
           $urandom_range(0, 15), "R7 R8 R9 random");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule